// File: doc/BRIEF.md
# System Control Register with Strobe and Window Decoder

This block is a small system-control register for a microcontroller-style bus, together with the decode logic that the register steers. It holds three bits of state. The first is a strobe-mode bit. The second is a read-only flag that records whether the last reset came from the external reset pin or from a watchdog overflow. The third is a bank-select bit. From these bits and the current bus address, the block drives an active-low external strobe. It also routes two small windows at the very top of the address space to one of two peripheral register groups, each of which has its own chip select.

In general mode the strobe marks every access to an external area. In I/O mode it marks only accesses that fall inside a fixed I/O range. The bank bit remaps the same two windows between a timer register group and a host-interface/keyboard register group. The four addresses between the two windows are never remapped. The strobe and the chip selects are combinational and are gated by the access-valid input. The register readback is registered.

Top module: `sysctl_strobe_map`

## Requirements
- R1: After external reset (`rst` high at a clock edge), a read of the control register at address `CTRL_ADDR` returns 0x08: flag bit 3 = 1, mode bit 6 = 0, bank bit 1 = 0.
- R2: A write to `CTRL_ADDR` loads data bit 6 into the mode bit and data bit 1 into the bank bit. Bits 7, 5, 4, 2 and 0 are not implemented: writes to them have no effect and they always read 0.
- R3: Bit 3 cannot be changed by a write, whatever data is written.
- R4: A watchdog reset (`wdt_rst` high at an edge while `rst` is low) clears bits 6, 3 and 1, so the register reads 0x00.
- R5: An external reset clears bits 6 and 1 and sets bit 3, and it takes priority when it coincides with a watchdog reset.
- R6: With bit 6 = 0, `strobe_n` is low exactly when `bus_valid` and `ext_area` are both high.
- R7: With bit 6 = 1, `strobe_n` is low exactly when `bus_valid` is high and `bus_addr` lies in 0xFFF000..0xFFFE4F inclusive, whatever the value of `ext_area`.
- R8: With bit 1 = 0, a valid access to 0xFFFFF0..0xFFFFF7 or 0xFFFFFC..0xFFFFFF raises `tmr_cs` and leaves `host_cs` low.
- R9: With bit 1 = 1, the same windows raise `host_cs` and leave `tmr_cs` low.
- R10: Addresses 0xFFFFF8..0xFFFFFB, all other addresses outside the windows, and cycles with `bus_valid` low assert neither chip select, and at most one chip select is ever high.
- R11: `rdata` shows the register image on the cycle after a valid read of `CTRL_ADDR`, and it is 0 after any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | External reset, synchronous, active high |
| wdt_rst | input | 1 | Watchdog-overflow reset pulse, synchronous, active high |
| bus_valid | input | 1 | A bus access is in progress this cycle |
| bus_rd | input | 1 | Read access |
| bus_wr | input | 1 | Write access |
| bus_addr | input | ADDR_W | Access address |
| bus_wdata | input | DATA_W | Write data |
| ext_area | input | 1 | The access targets an external area |
| strobe_n | output | 1 | Active-low address or I/O strobe |
| tmr_cs | output | 1 | Timer register group select |
| host_cs | output | 1 | Host-interface/keyboard register group select |
| rdata | output | DATA_W | Register readback |

## Verification
`strobe_n`, `tmr_cs` and `host_cs` settle in the same cycle as their address and valid inputs. The bench therefore drives these inputs after a falling edge and samples the outputs 1 ns later, sweeping every address of the I/O range region and of the top page in both register settings. A register write or reset takes effect at the next rising edge. `rdata` appears one rising edge after the read, so each read task holds the request across exactly one rising edge and samples just after the following falling edge. Reset-priority and write-masking cases are checked only through that readback.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned BIT_MODE = 6;
  localparam int unsigned BIT_SRC  = 3;
  localparam int unsigned BIT_BANK = 1;

  typedef struct packed {
    logic io_mode;
    logic src_ext;
    logic bank_host;
  } sysctl_state_t;
endpackage

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wdt_rst,
  input  logic              wr_hit,
  input  logic              rd_hit,
  input  logic [DATA_W-1:0] wdata,
  output sysctl_state_t     st,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [DATA_W-1:0] WR_MASK =
    DATA_W'((1 << BIT_MODE) | (1 << BIT_BANK));

  logic [DATA_W-1:0] image;

  always_ff @(posedge clk) begin
    if (rst) begin
      st.io_mode   <= 1'b0;
      st.bank_host <= 1'b0;
      st.src_ext   <= 1'b1;
    end else if (wdt_rst) begin
      st.io_mode   <= 1'b0;
      st.bank_host <= 1'b0;
      st.src_ext   <= 1'b0;
    end else if (wr_hit) begin
      st.io_mode   <= wdata[BIT_MODE];
      st.bank_host <= wdata[BIT_BANK];
    end
  end

  always_comb begin
    image           = '0;
    image[BIT_MODE] = st.io_mode;
    image[BIT_SRC]  = st.src_ext;
    image[BIT_BANK] = st.bank_host;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_hit) rdata <= image;
    else             rdata <= '0;
  end

  // R3: the flag moves only on a reset
  p_src_stable_r3: assert property (@(posedge clk) disable iff (rst)
    !wdt_rst |=> $stable(st.src_ext));
  // R4: watchdog reset clears all three bits
  p_wdt_clear_r4: assert property (@(posedge clk) disable iff (rst)
    wdt_rst |=> (!st.src_ext && !st.io_mode && !st.bank_host));
  // R2: the writable bits follow the data, the rest of the data is dropped
  p_wr_take_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && !wdt_rst) |=> ((image & WR_MASK) == ($past(wdata) & WR_MASK)));
  // R11: no read means quiet readback
  p_rdata_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> (rdata == '0));
endmodule

// File: rtl/sysctl_win_dec.sv
module sysctl_win_dec #(
  parameter int unsigned        ADDR_W   = 24,
  parameter int unsigned        DECODE_W = 24,
  parameter logic [ADDR_W-1:0]  WA_LO    = 24'hFFFFF0,
  parameter logic [ADDR_W-1:0]  WA_HI    = 24'hFFFFF7,
  parameter logic [ADDR_W-1:0]  WB_LO    = 24'hFFFFFC,
  parameter logic [ADDR_W-1:0]  WB_HI    = 24'hFFFFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bank_host,
  output logic              tmr_cs,
  output logic              host_cs
);
  localparam int unsigned N_WIN = 2;
  localparam logic [DECODE_W-1:0] LO_A = WA_LO[DECODE_W-1:0];
  localparam logic [DECODE_W-1:0] HI_A = WA_HI[DECODE_W-1:0];
  localparam logic [DECODE_W-1:0] LO_B = WB_LO[DECODE_W-1:0];
  localparam logic [DECODE_W-1:0] HI_B = WB_HI[DECODE_W-1:0];

  logic [DECODE_W-1:0] a_dec;
  logic [N_WIN-1:0]    hit;
  logic                in_win;

  assign a_dec = bus_addr[DECODE_W-1:0];

  for (genvar i = 0; i < N_WIN; i++) begin : g_win
    localparam logic [DECODE_W-1:0] LO = (i == 0) ? LO_A : LO_B;
    localparam logic [DECODE_W-1:0] HI = (i == 0) ? HI_A : HI_B;
    assign hit[i] = (a_dec >= LO) && (a_dec <= HI);
  end

  assign in_win  = bus_valid && (|hit);
  assign tmr_cs  = in_win && !bank_host;
  assign host_cs = in_win &&  bank_host;

  // R10: never both selects
  p_cs_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tmr_cs, host_cs}));
  // R10: no select without a valid access
  p_cs_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |-> (!tmr_cs && !host_cs));
endmodule

// File: rtl/sysctl_strobe_gen.sv
module sysctl_strobe_gen #(
  parameter int unsigned       ADDR_W   = 24,
  parameter int unsigned       DECODE_W = 24,
  parameter logic [ADDR_W-1:0] IO_LO    = 24'hFFF000,
  parameter logic [ADDR_W-1:0] IO_HI    = 24'hFFFE4F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              ext_area,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              io_mode,
  output logic              strobe_n
);
  localparam logic [DECODE_W-1:0] LO_D = IO_LO[DECODE_W-1:0];
  localparam logic [DECODE_W-1:0] HI_D = IO_HI[DECODE_W-1:0];

  logic [DECODE_W-1:0] a_dec;
  logic                in_io;
  logic                fire;

  assign a_dec    = bus_addr[DECODE_W-1:0];
  assign in_io    = (a_dec >= LO_D) && (a_dec <= HI_D);
  assign fire     = io_mode ? in_io : ext_area;
  assign strobe_n = !(bus_valid && fire);

  // R6: idle bus leaves the strobe high
  p_strobe_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |-> strobe_n);
  // R6: in general mode a low strobe implies an external access
  p_mode0_ext_r6: assert property (@(posedge clk) disable iff (rst)
    (!io_mode && !strobe_n) |-> ext_area);
endmodule

// File: rtl/sysctl_strobe_map.sv
module sysctl_strobe_map
  import sysctl_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 24,
  parameter int unsigned       DATA_W    = 8,
  parameter int unsigned       DECODE_W  = 24,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 24'hFFFFC4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wdt_rst,
  input  logic              bus_valid,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              ext_area,
  output logic              strobe_n,
  output logic              tmr_cs,
  output logic              host_cs,
  output logic [DATA_W-1:0] rdata
);
  sysctl_state_t st;
  logic          reg_hit, wr_hit, rd_hit;

  assign reg_hit = bus_valid && (bus_addr == CTRL_ADDR);
  assign wr_hit  = reg_hit && bus_wr;
  assign rd_hit  = reg_hit && bus_rd;

  sysctl_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wdt_rst(wdt_rst),
    .wr_hit(wr_hit), .rd_hit(rd_hit), .wdata(bus_wdata),
    .st(st), .rdata(rdata)
  );

  sysctl_strobe_gen #(.ADDR_W(ADDR_W), .DECODE_W(DECODE_W)) u_strobe (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .ext_area(ext_area),
    .bus_addr(bus_addr), .io_mode(st.io_mode), .strobe_n(strobe_n)
  );

  sysctl_win_dec #(.ADDR_W(ADDR_W), .DECODE_W(DECODE_W)) u_dec (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bank_host(st.bank_host), .tmr_cs(tmr_cs), .host_cs(host_cs)
  );
endmodule

// File: tb/sysctl_strobe_map_tb_top.sv
module sysctl_strobe_map_tb_top;
  localparam logic [23:0] CTRL = 24'hFFFFC4;

  logic        clk = 1'b0;
  logic        rst = 1'b1, wdt_rst = 1'b0;
  logic        bus_valid = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0, ext_area = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        strobe_n, tmr_cs, host_cs;
  logic [7:0]  rdata;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  sysctl_strobe_map dut_i (
    .clk(clk), .rst(rst), .wdt_rst(wdt_rst), .bus_valid(bus_valid),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ext_area(ext_area), .strobe_n(strobe_n),
    .tmr_cs(tmr_cs), .host_cs(host_cs), .rdata(rdata)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [7:0] d);
    @(negedge clk);
    bus_valid = 1; bus_wr = 1; bus_addr = CTRL; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_wr = 0;
  endtask

  task automatic read_reg(output logic [7:0] d);
    @(negedge clk);
    bus_valid = 1; bus_rd = 1; bus_addr = CTRL;
    @(negedge clk);
    bus_valid = 0; bus_rd = 0;
    #1 d = rdata;
  endtask

  task automatic ext_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
  endtask

  task automatic wdt_reset();
    @(negedge clk); wdt_rst = 1;
    @(negedge clk); wdt_rst = 0;
  endtask

  function automatic bit in_io(input logic [23:0] a);
    return (a >= 24'hFFF000) && (a <= 24'hFFFE4F);
  endfunction

  function automatic bit in_win(input logic [23:0] a);
    return ((a >= 24'hFFFFF0) && (a <= 24'hFFFFF7)) || (a >= 24'hFFFFFC);
  endfunction

  task automatic sweep_strobe(input bit mode, input logic [7:0] top);
    for (int lo = 0; lo < 65536; lo++) begin
      for (int e = 0; e < 2; e++) begin
        bit exp_low;
        bus_valid = 1; bus_addr = {top, 16'(lo)}; ext_area = e[0];
        #1;
        exp_low = mode ? in_io(bus_addr) : e[0];
        if (mode) check(strobe_n == !exp_low, "R7 strobe io mode", {8'h0, bus_addr}, 32'(!exp_low));
        else      check(strobe_n == !exp_low, "R6 strobe general mode", {8'h0, bus_addr}, 32'(!exp_low));
      end
    end
    bus_valid = 0; ext_area = 0;
    #1 check(strobe_n == 1'b1, "R6 idle strobe", 32'(strobe_n), 1);
  endtask

  task automatic sweep_win(input bit bank, input logic [7:0] top);
    for (int lo = 0; lo < 256; lo++) begin
      bit w;
      bus_valid = 1; bus_addr = {top, 8'hFF, 8'(lo)};
      #1;
      w = in_win(bus_addr);
      if (!w)        check(!tmr_cs && !host_cs, "R10 outside windows", {tmr_cs, host_cs}, 0);
      else if (bank) check(host_cs && !tmr_cs, "R9 host group", {tmr_cs, host_cs}, 1);
      else           check(tmr_cs && !host_cs, "R8 timer group", {tmr_cs, host_cs}, 2);
      bus_valid = 0;
      #1 check(!tmr_cs && !host_cs, "R10 invalid access", {tmr_cs, host_cs}, 0);
    end
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    read_reg(d);  check(d == 8'h08, "R1 reset value", d, 8'h08);
    read_reg(d);  check(d == 8'h08, "R11 second read", d, 8'h08);
    @(negedge clk); #1 check(rdata == 0, "R11 idle readback", rdata, 0);

    write_reg(8'hF7); read_reg(d);
    check(d == 8'h4A, "R2 write ones / R3 flag kept", d, 8'h4A);
    write_reg(8'h08); read_reg(d);
    check(d == 8'h08, "R2 clear writable bits", d, 8'h08);
    write_reg(8'h40); read_reg(d);
    check(d == 8'h48, "R2 mode bit only", d, 8'h48);
    write_reg(8'hBD); read_reg(d);
    check(d == 8'h08, "R2 unimplemented ignored", d, 8'h08);

    // wrong address write has no effect
    @(negedge clk); bus_valid = 1; bus_wr = 1; bus_addr = CTRL + 1; bus_wdata = 8'hFF;
    @(negedge clk); bus_valid = 0; bus_wr = 0;
    read_reg(d); check(d == 8'h08, "R2 other address ignored", d, 8'h08);

    write_reg(8'h42); wdt_reset(); read_reg(d);
    check(d == 8'h00, "R4 watchdog reset", d, 8'h00);
    write_reg(8'hFF); read_reg(d);
    check(d == 8'h42, "R3 flag not settable", d, 8'h42);
    ext_reset(); read_reg(d);
    check(d == 8'h08, "R5 external reset", d, 8'h08);
    write_reg(8'h42); wdt_reset();
    @(negedge clk); rst = 1; wdt_rst = 1;
    @(negedge clk); rst = 0; wdt_rst = 0;
    read_reg(d); check(d == 8'h08, "R5 priority over watchdog", d, 8'h08);

    // strobe sweeps
    write_reg(8'h00); sweep_strobe(1'b0, 8'hFF);
    write_reg(8'h40); sweep_strobe(1'b1, 8'hFF);
    sweep_strobe(1'b1, 8'h7F);
    bus_valid = 0; #1 check(strobe_n == 1'b1, "R7 idle strobe", 32'(strobe_n), 1);

    // window sweeps
    write_reg(8'h00); sweep_win(1'b0, 8'hFF); sweep_win(1'b0, 8'h00);
    write_reg(8'h02); sweep_win(1'b1, 8'hFF); sweep_win(1'b1, 8'h3F);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule